// File: doc/BRIEF.md
# Memory Init and Test Sequencer

This engine walks a contiguous range of cache-line indices on a simple request/response memory port. It starts at line zero and ends at a programmed last line. It is used during bring-up in one of two ways. In the first, it clears memory so that check bits start out consistent. In the second, it proves the memory by writing a fixed pattern, reading it back, then doing the same with the pattern inverted.

Software loads a mode code and the last line index and pulses start. It then polls a busy flag. When busy drops, it reads a 32-bit status word. That word carries one sticky mismatch bit per byte lane, and a dedicated clear input wipes it. Only one request is in flight at a time. A request is held until the memory accepts it. A read is compared when its response returns.

Top module: `memsweep_top`

## Requirements
- R1: After reset, busy, the request strobe and the whole status word are zero.
- R2: Mode code 2'b01 (init) runs one pass of writes to lines 0 through the last line, in ascending order, with all-zero data and no reads.
- R3: Mode code 2'b10 (test) runs four passes over lines 0 through the last line, each in ascending order. The passes are a write pass, a read pass, a write pass and a read pass.
- R4: In the first two test passes, 16-bit chunk k of the data word (bits 16k+15:16k) is 0x5AA5 for even k and 0xA55A for odd k, so the 64-bit word is 0xA55A5AA5A55A5AA5. The last two passes use the bitwise complement.
- R5: A read response whose byte lane i (data bits 8i+7:8i) differs from the pass data sets status bit 8+i. No other status bit is set by a compare.
- R6: At the end of each read pass the run stops if any status bit is set, and the remaining passes issue no requests.
- R7: Busy rises on the cycle after an accepted start and stays high until the last pass has finished. No request is issued while busy is low.
- R8: A start with any other mode code issues no requests and leaves busy low, and the status word becomes 0xFFFFFFFF.
- R9: Status bits are sticky until the clear input. If a clear and a lane mismatch land in the same cycle, the old bits are cleared and the new mismatch bit stays set.
- R10: A start while busy is ignored: the running sweep keeps its mode and last line.
- R11: A request holds its write flag, line index and data stable until accepted. After a read is accepted, no further request is issued until its response has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle run request |
| mode | input | 2 | 01 init, 10 test, others rejected |
| lastLine | input | ADDR_W | Index of the final cache line |
| errClear | input | 1 | Wipes the status word |
| busy | output | 1 | Run in progress |
| errStatus | output | 32 | Lane mismatch bits at 15:8, or all ones after a rejected mode |
| memReq | output | 1 | Request valid |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | ADDR_W | Cache-line index |
| memWdata | output | DATA_W | Write data and compare reference |
| memReady | input | 1 | Memory accepts the request this cycle |
| memRvalid | input | 1 | Read response valid |
| memRdata | input | DATA_W | Read response data |

## Verification
Two functions can fall in the same cycle: a clear from software and a mismatch being recorded from a read response. The bench provokes this by raising the clear in exactly the cycle it returns a corrupted read response. Old bits from an earlier run are already present. The result is judged by the final status word, which must hold only the new lane bit.

// File: rtl/memsweep_pkg.sv
package memsweep_pkg;
  localparam logic [1:0] MODE_INIT = 2'b01;
  localparam logic [1:0] MODE_TEST = 2'b10;
  localparam int STAT_W   = 32;
  localparam int LANE_LSB = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_PASS = 2'd3
  } sweepState_t;

  typedef struct packed {
    logic loadCfg;
    logic lineClr;
    logic lineInc;
    logic capture;
    logic invert;
    logic zeroData;
    logic rejectMode;
  } sweepCtl_t;
endpackage

// File: rtl/memsweep_dp.sv
module memsweep_dp
  import memsweep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  sweepCtl_t         ctl,
  input  logic [ADDR_W-1:0] lastLine,
  input  logic              errClear,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] lineIdx,
  output logic              lineIsLast,
  output logic [DATA_W-1:0] memWdata,
  output logic [STAT_W-1:0] errStatus,
  output logic              anyErr
);
  localparam int LANES  = DATA_W / 8;
  localparam int CHUNKS = DATA_W / 16;

  logic [ADDR_W-1:0] runLast;
  logic [DATA_W-1:0] basePat;
  logic [LANES-1:0]  laneErr;
  logic [STAT_W-1:0] newBits;
  logic [STAT_W-1:0] statNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLast <= '0;
      lineIdx <= '0;
    end else begin
      if (ctl.loadCfg) runLast <= lastLine;
      if (ctl.lineClr)      lineIdx <= '0;
      else if (ctl.lineInc) lineIdx <= lineIdx + 1'b1;
    end
  end

  assign lineIsLast = (lineIdx == runLast);

  for (genvar k = 0; k < CHUNKS; k++) begin : g_chunk
    if (k % 2 == 0) begin : g_even
      assign basePat[16*k +: 16] = 16'h5AA5;
    end else begin : g_odd
      assign basePat[16*k +: 16] = 16'hA55A;
    end
  end

  assign memWdata = ctl.zeroData ? '0 : (ctl.invert ? ~basePat : basePat);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneErr[i] = ctl.capture && (memRdata[8*i +: 8] != memWdata[8*i +: 8]);
  end

  always_comb begin
    newBits = '0;
    newBits[LANE_LSB +: LANES] = laneErr;
    if (ctl.rejectMode) statNext = '1;
    else                statNext = (errClear ? '0 : errStatus) | newBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errStatus <= '0;
    else       errStatus <= statNext;
  end

  assign anyErr = |errStatus;

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    !errClear |=> ((errStatus | $past(errStatus)) == errStatus));

  assert_reject_ones_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rejectMode |=> (errStatus == '1));
endmodule

// File: rtl/memsweep_ctl.sv
module memsweep_ctl
  import memsweep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic       lineIsLast,
  input  logic       anyErr,
  input  logic       memReady,
  input  logic       memRvalid,
  output sweepCtl_t  ctl,
  output logic       busy,
  output logic       memReq,
  output logic       memWe
);
  sweepState_t state, stateNext;
  logic       runTest, runTestNext;
  logic [1:0] passIdx, passNext;
  logic       isWrite;

  assign isWrite = !runTest || !passIdx[0];

  always_comb begin
    stateNext    = state;
    runTestNext  = runTest;
    passNext     = passIdx;
    ctl          = '0;
    ctl.invert   = runTest && passIdx[1];
    ctl.zeroData = !runTest;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (mode == MODE_INIT || mode == MODE_TEST) begin
            ctl.loadCfg = 1'b1;
            ctl.lineClr = 1'b1;
            runTestNext = (mode == MODE_TEST);
            passNext    = 2'd0;
            stateNext   = ST_REQ;
          end else begin
            ctl.rejectMode = 1'b1;
          end
        end
      end
      ST_REQ: begin
        if (memReady) begin
          if (!isWrite)        stateNext = ST_WAIT;
          else if (lineIsLast) stateNext = ST_PASS;
          else                 ctl.lineInc = 1'b1;
        end
      end
      ST_WAIT: begin
        if (memRvalid) begin
          ctl.capture = 1'b1;
          if (lineIsLast) stateNext = ST_PASS;
          else begin
            ctl.lineInc = 1'b1;
            stateNext   = ST_REQ;
          end
        end
      end
      ST_PASS: begin
        if (!runTest || passIdx == 2'd3 || (passIdx[0] && anyErr)) begin
          stateNext = ST_IDLE;
        end else begin
          passNext    = passIdx + 2'd1;
          ctl.lineClr = 1'b1;
          stateNext   = ST_REQ;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      runTest <= 1'b0;
      passIdx <= 2'd0;
    end else begin
      state   <= stateNext;
      runTest <= runTestNext;
      passIdx <= passNext;
    end
  end

  assign busy   = (state != ST_IDLE);
  assign memReq = (state == ST_REQ);
  assign memWe  = isWrite;

  assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memWe));

  assert_one_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memReady && !memWe |=> !memReq);
endmodule

// File: rtl/memsweep_top.sv
module memsweep_top
  import memsweep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] lastLine,
  input  logic              errClear,
  output logic              busy,
  output logic [31:0]       errStatus,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata
);
  sweepCtl_t ctl;
  logic      lineIsLast;
  logic      anyErr;

  memsweep_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .lineIsLast(lineIsLast), .anyErr(anyErr),
    .memReady(memReady), .memRvalid(memRvalid),
    .ctl(ctl), .busy(busy), .memReq(memReq), .memWe(memWe)
  );

  memsweep_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lastLine(lastLine),
    .errClear(errClear), .memRdata(memRdata),
    .lineIdx(memAddr), .lineIsLast(lineIsLast),
    .memWdata(memWdata), .errStatus(errStatus), .anyErr(anyErr)
  );

  assert_hold_line_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> $stable(memAddr) && $stable(memWdata));

  assert_init_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && ctl.zeroData |-> memWe && (memWdata == '0));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !memReq);
endmodule

// File: tb/tb_memsweep_top.sv
`timescale 1ns/1ps
module tb_memsweep_top;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 64;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } item_t;

  logic clk = 0, rstN = 0, start = 0, tbClr = 0, memClr = 0;
  logic [1:0] mode = 0;
  logic [ADDR_W-1:0] lastLine = 0;
  logic errClear;
  logic busy, memReq, memWe, memReady = 0, memRvalid = 0;
  logic [31:0] errStatus;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata, memRdata = 0;

  assign errClear = tbClr | memClr;
  always #10 clk = ~clk;

  memsweep_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

  int tests = 0, fails = 0;
  item_t expQ[$];
  logic [DATA_W-1:0] mem [0:(1<<ADDR_W)-1];
  int readCount = 0, faultRead = -1, faultLane = 0, readyCnt = 0;
  bit clrWithFault = 0, pendRead = 0, pendFault = 0;
  int pendDelay = 0;
  logic [DATA_W-1:0] pendData;

  function automatic logic [DATA_W-1:0] pat(bit inv);
    logic [DATA_W-1:0] p;
    for (int k = 0; k < DATA_W/16; k++) p[16*k +: 16] = (k % 2 == 0) ? 16'h5AA5 : 16'hA55A;
    return inv ? ~p : p;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected request stream
  task automatic expectRun(bit isTest, int last, int passes);
    item_t it;
    for (int p = 0; p < passes; p++)
      for (int a = 0; a <= last; a++) begin
        it.we   = isTest ? (p % 2 == 0) : 1'b1;
        it.addr = a[ADDR_W-1:0];
        it.data = isTest ? pat(p >= 2) : '0;
        expQ.push_back(it);
      end
  endtask

  // memory model and monitor side of the scoreboard
  always @(negedge clk) begin
    item_t e;
    memRvalid = 0;
    memClr = 0;
    if (pendRead) begin
      if (pendDelay == 0) begin
        memRvalid = 1;
        memRdata  = pendData;
        if (pendFault) memClr = clrWithFault;
        pendRead = 0;
      end else pendDelay--;
    end
    readyCnt++;
    memReady = (readyCnt % 4) != 1;
    if (rstN && memReq && memReady) begin
      if (expQ.size() == 0) begin
        check(0, "R3/R6/R8/R10 unexpected request", {53'd0, memWe, memAddr}, 64'd0);
      end else begin
        e = expQ.pop_front();
        check(memWe == e.we && memAddr == e.addr, "R2/R3 order", {53'd0, memWe, memAddr}, {53'd0, e.we, e.addr});
        if (memWe) begin
          check(memWdata == e.data, "R2/R4 data", memWdata, e.data);
          mem[memAddr] = memWdata;
        end
      end
      if (!memWe) begin
        pendRead  = 1;
        pendDelay = readCount % 3;
        pendData  = mem[memAddr];
        pendFault = (readCount == faultRead);
        if (pendFault) pendData = pendData ^ (64'hFF << (8*faultLane));
        readCount++;
      end
    end
  end

  task automatic runSweep(logic [1:0] m, int last, string req);
    readCount = 0;
    @(negedge clk);
    start = 1; mode = m; lastLine = last[ADDR_W-1:0];
    @(negedge clk);
    start = 0;
    check(busy == 1, "R7 busy rise", {63'd0, busy}, 64'd1);
    for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
    check(busy == 0, "R7 busy fall", {63'd0, busy}, 64'd0);
    check(expQ.size() == 0, req, expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic clearStatus();
    @(negedge clk); tbClr = 1;
    @(negedge clk); tbClr = 0;
    check(errStatus == 0, "R9 clear", errStatus, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && memReq == 0 && errStatus == 0, "R1 reset", {busy, memReq, errStatus}, 0);
    rstN = 1;
    @(negedge clk);

    expectRun(0, 5, 1);                       // R2 init sweep
    runSweep(2'b01, 5, "R2 init count");
    check(errStatus == 0, "R2 status", errStatus, 0);

    expectRun(1, 7, 4);                       // R3/R4 clean test
    runSweep(2'b10, 7, "R3 four passes");
    check(errStatus == 0, "R3 status", errStatus, 0);

    faultRead = 3; faultLane = 2;             // R5/R6 fault in first read pass
    expectRun(1, 7, 2);
    runSweep(2'b10, 7, "R6 early stop");
    check(errStatus == 32'h0000_0400, "R5 lane2", errStatus, 32'h400);
    clearStatus();

    faultRead = 8; faultLane = 7;             // R5 fault in second read pass
    expectRun(1, 7, 4);
    runSweep(2'b10, 7, "R3 full with late fault");
    check(errStatus == 32'h0000_8000, "R5 lane7", errStatus, 32'h8000);

    faultRead = -1;                           // R9 sticky bit aborts next run
    expectRun(1, 3, 2);
    runSweep(2'b10, 3, "R9 sticky abort");
    check(errStatus == 32'h0000_8000, "R9 sticky", errStatus, 32'h8000);

    faultRead = 2; faultLane = 0; clrWithFault = 1;   // R9 clear meets capture
    expectRun(1, 7, 2);
    runSweep(2'b10, 7, "R9 clear+capture run");
    check(errStatus == 32'h0000_0100, "R9 clear+capture", errStatus, 32'h100);
    clrWithFault = 0; faultRead = -1;
    clearStatus();

    for (int b = 0; b < 2; b++) begin         // R8 rejected codes
      @(negedge clk); start = 1; mode = (b == 0) ? 2'b00 : 2'b11;
      @(negedge clk); start = 0;
      check(busy == 0 && errStatus == 32'hFFFF_FFFF, "R8 reject", {busy, errStatus}, 33'h0_FFFF_FFFF);
      repeat (4) @(negedge clk);
      check(busy == 0, "R8 no run", {63'd0, busy}, 0);
    end
    clearStatus();

    expectRun(0, 3, 1);                       // R10 start while busy
    readCount = 0;
    @(negedge clk); start = 1; mode = 2'b01; lastLine = 3;
    @(negedge clk); start = 1; mode = 2'b10; lastLine = 9;
    @(negedge clk); start = 0;
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(busy == 0 && expQ.size() == 0, "R10 ignored start", expQ.size(), 0);
    check(errStatus == 0, "R10 status", errStatus, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule